// File: doc/BRIEF.md
# Half-Rate Sample Demultiplexer with Realignable Ready Clock

This block takes a stream of sample words, one per rising edge of the sample clock, and deals them out in pairs onto two ports that each run at half the sample rate. The lead port carries the newer sample of each pair and the trail port carries the older one. A half-rate ready clock goes with the two ports, and both ports change only on its rising edge.

Several of these blocks can be brought into one common ready-clock phase with a synchronizing reset input. That input is sampled on the rising sample-clock edge and passed through a delay line to a reset output. The reset output can reset demultiplexers further down the chain, and its falling edge marks the first aligned pair on the ports. On that falling edge the ready clock is forced high. If it was already heading high, nothing is disturbed. Otherwise it stays high for one extra sample cycle, and from then on the samples land on the two ports in the opposite order.

Half-cycle latencies come from output registers that are clocked on the falling sample-clock edge. An active-low power-on reset puts the divider into a known phase, so a single device needs no synchronizing reset.

Top module: `dmx_demux2`

## Requirements
- R1: While `por_n` is low, `dready_o`, `rst_out_o`, `lead_o` and `trail_o` are all zero, whatever the other inputs do.
- R2: Outside a realignment, `dready_o` changes level on every falling sample-clock edge. After `por_n` is released, its first rise comes on the falling edge that follows the first rising edge.
- R3: When `dready_o` rises on the falling edge after rising edge e, `lead_o` takes the sample captured at rising edge e-7, which is a latency of 7.5 sample cycles.
- R4: On the same `dready_o` rise, `trail_o` takes the sample captured at rising edge e-8 (8.5 cycles). The trail port always holds the older sample of the pair.
- R5: `lead_o` and `trail_o` change only on a rising edge of `dready_o`.
- R6: `rst_out_o` repeats `sync_rst_i` 6.5 sample cycles later. The value sampled at rising edge e appears on the falling edge after rising edge e+6.
- R7: `dready_o` keeps toggling while `rst_out_o` is high.
- R8: On the falling edge where `rst_out_o` goes low, `dready_o` is high. If it was low just before, this is an ordinary toggle. If it was already high, it stays high for one extra sample cycle, and no port update takes place on that extra cycle.
- R9: Synchronizing reset pulses of one or more sample cycles are each handled according to R6 to R8.
- R10: After a held (swallowed) cycle, the gap between port updates is three sample cycles once, and the parity of the samples placed on each port is reversed. After a realignment with no held cycle, the update spacing stays at two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; the sample is taken on the rising edge, outputs change on the falling edge |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| smp_i | input | DW | Sample word, one per sample cycle |
| sync_rst_i | input | 1 | Synchronizing reset, active high, sampled on the rising edge |
| lead_o | output | DW | Newer sample of each pair, half rate |
| trail_o | output | DW | Older sample of each pair, half rate |
| dready_o | output | 1 | Half-rate ready clock; ports update on its rising edge |
| rst_out_o | output | 1 | Delayed synchronizing reset for downstream devices |

## Verification
Two kinds of internal fault show up at the ports: a wrong divider phase and a wrong tap in a delay line. A divider phase that fails to toggle or is forced on the wrong edge shows within one sample cycle as a held `dready_o` level. It also shows up as a port-update spacing other than two cycles. A wrong tap in the sample delay line shows as a port word that differs from the sample of the expected age, at the very next ready-clock rise. A wrong tap in the reset delay line shows as `rst_out_o` being early or late by whole cycles. It also moves the realignment edge, and within three sample cycles that edge in turn changes which parity of sample reaches the lead port.

// File: rtl/dmx_pkg.sv
`timescale 1ns/1ps
package dmx_pkg;
   // Depth of a delay line that must expose taps 0..max_tap.
   function automatic int unsigned taps_for(input int unsigned max_tap);
      return max_tap + 1;
   endfunction
endpackage

// File: rtl/dmx_tap_line.sv
`timescale 1ns/1ps
module dmx_tap_line #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 9
) (
   input  logic                      clk,
   input  logic                      arst_n,
   input  logic [W-1:0]              d,
   output logic [DEPTH-1:0][W-1:0]   taps
);
   if (W < 1)     begin : g_bad_w $error("tap line width must be nonzero"); end
   if (DEPTH < 2) begin : g_bad_d $error("tap line needs at least two stages"); end

   // taps[0] holds the value taken at the latest rising edge, taps[k] is k edges older.
   for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge arst_n)
            if (!arst_n) taps[0] <= '0;
            else         taps[0] <= d;
      end else begin : g_body
         always_ff @(posedge clk or negedge arst_n)
            if (!arst_n) taps[k] <= '0;
            else         taps[k] <= taps[k-1];
      end
   end
endmodule

// File: rtl/dmx_phase_ctl.sv
`timescale 1ns/1ps
module dmx_phase_ctl (
   input  logic clk,
   input  logic arst_n,
   input  logic realign,   // rising-domain: this edge is where the delayed reset drops
   output logic dready,
   output logic load       // high between the edge that raises phase and the falling edge
);
   logic phase_q;

   // Divider phase, rising edge. A realignment forces the high phase.
   always_ff @(posedge clk or negedge arst_n)
      if (!arst_n)      phase_q <= 1'b0;
      else if (realign) phase_q <= 1'b1;
      else              phase_q <= ~phase_q;

   // Ready clock, retimed to the falling edge for the half-cycle offset.
   always_ff @(negedge clk or negedge arst_n)
      if (!arst_n) dready <= 1'b0;
      else         dready <= phase_q;

   // A port update belongs to a low-to-high transition of the ready clock only.
   assign load = phase_q & ~dready;
endmodule

// File: rtl/dmx_out_stage.sv
`timescale 1ns/1ps
module dmx_out_stage #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         load,
   input  logic [W-1:0] newer,
   input  logic [W-1:0] older,
   input  logic         rst_tap,
   output logic [W-1:0] lead,
   output logic [W-1:0] trail,
   output logic         rst_out
);
   always_ff @(negedge clk or negedge arst_n)
      if (!arst_n) begin
         lead  <= '0;
         trail <= '0;
      end else if (load) begin
         lead  <= newer;
         trail <= older;
      end

   always_ff @(negedge clk or negedge arst_n)
      if (!arst_n) rst_out <= 1'b0;
      else         rst_out <= rst_tap;
endmodule

// File: rtl/dmx_demux2.sv
`timescale 1ns/1ps
module dmx_demux2 #(
   parameter int unsigned DW      = 8,
   parameter int unsigned LEAD_LAT = 7   // whole cycles; the falling-edge stage adds one half
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic [DW-1:0] smp_i,
   input  logic          sync_rst_i,
   output logic [DW-1:0] lead_o,
   output logic [DW-1:0] trail_o,
   output logic          dready_o,
   output logic          rst_out_o
);
   import dmx_pkg::*;

   localparam int unsigned TRAIL_LAT = LEAD_LAT + 1;
   localparam int unsigned RST_LAT   = LEAD_LAT - 1;
   localparam int unsigned SMP_DEPTH = taps_for(TRAIL_LAT);
   localparam int unsigned RST_DEPTH = taps_for(RST_LAT);

   if (LEAD_LAT < 2) begin : g_bad_lat $error("LEAD_LAT must be at least 2"); end

   logic [SMP_DEPTH-1:0][DW-1:0] smp_taps;
   logic [RST_DEPTH-1:0][0:0]    rst_taps;
   logic                         realign;
   logic                         load;

   dmx_tap_line #(.W(DW), .DEPTH(SMP_DEPTH)) u_smp_line (
      .clk(clk), .arst_n(por_n), .d(smp_i), .taps(smp_taps));

   dmx_tap_line #(.W(1), .DEPTH(RST_DEPTH)) u_rst_line (
      .clk(clk), .arst_n(por_n), .d(sync_rst_i), .taps(rst_taps));

   // The last reset tap is about to drop: force the phase on this same edge.
   assign realign = rst_taps[RST_LAT][0] & ~rst_taps[RST_LAT-1][0];

   dmx_phase_ctl u_phase (
      .clk(clk), .arst_n(por_n), .realign(realign), .dready(dready_o), .load(load));

   dmx_out_stage #(.W(DW)) u_out (
      .clk(clk), .arst_n(por_n), .load(load),
      .newer(smp_taps[LEAD_LAT]), .older(smp_taps[TRAIL_LAT]),
      .rst_tap(rst_taps[RST_LAT][0]),
      .lead(lead_o), .trail(trail_o), .rst_out(rst_out_o));

   // ---------------- assertions ----------------
   logic [3:0] warm_q;   // rising edges since power-on reset, saturating
   always_ff @(posedge clk or negedge por_n)
      if (!por_n)              warm_q <= '0;
      else if (warm_q != 4'hF) warm_q <= warm_q + 4'd1;

   // R2 / R8: a held ready level is only allowed right where the reset output drops
   a_r2_toggle: assert property (@(posedge clk) disable iff (!por_n)
      (warm_q >= 4'd2 && dready_o == $past(dready_o)) |-> (!rst_out_o && $past(rst_out_o)));

   // R8: ready clock is high when the reset output falls
   a_r8_fall_high: assert property (@(posedge clk) disable iff (!por_n)
      (warm_q >= 4'd2 && $fell(rst_out_o)) |-> dready_o);

   // R5: port words move only with a ready-clock rise
   a_r5_hold: assert property (@(posedge clk) disable iff (!por_n)
      (warm_q >= 4'd2 && (lead_o != $past(lead_o) || trail_o != $past(trail_o)))
         |-> $rose(dready_o));

   if (LEAD_LAT == 7) begin : g_lat_chk
      // R3, R4: sample ages on each port
      a_r3_lead_age: assert property (@(posedge clk) disable iff (!por_n)
         (warm_q >= 4'd10 && $rose(dready_o)) |-> lead_o == $past(smp_i, 8));
      a_r4_trail_age: assert property (@(posedge clk) disable iff (!por_n)
         (warm_q >= 4'd10 && $rose(dready_o)) |-> trail_o == $past(smp_i, 9));
      // R6: reset output delay
      a_r6_rst_delay: assert property (@(posedge clk) disable iff (!por_n)
         (warm_q >= 4'd8) |-> rst_out_o == $past(sync_rst_i, 7));
   end
endmodule

// File: tb/dmx_demux2_tb_top.sv
`timescale 1ns/1ps
module dmx_demux2_tb_top;
   localparam int OFS = 16;
   localparam int HMAX = 4096;
   localparam int NSCN = 8;
   // {idle cycles before pulse, pulse length}
   localparam int SCN [NSCN][2] = '{'{5,2}, '{6,2}, '{4,1}, '{9,3}, '{10,8}, '{3,2}, '{20,5}, '{7,1}};

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic [7:0] smp_i = 8'h00;
   logic       sync_rst_i = 1'b0;
   logic [7:0] lead_o, trail_o;
   logic       dready_o, rst_out_o;

   dmx_demux2 dut_i (.clk(clk), .por_n(por_n), .smp_i(smp_i), .sync_rst_i(sync_rst_i),
                     .lead_o(lead_o), .trail_o(trail_o), .dready_o(dready_o), .rst_out_o(rst_out_o));

   always #2.5 clk = ~clk;

   int total = 0, fails = 0, e = 0, last_chg = -1;
   bit done = 0, swallow_pend = 0, prev_dr = 0;
   logic [7:0] dh [HMAX];
   bit rh [HMAX];
   bit ph [HMAX];
   logic [7:0] lead_m = 0, trail_m = 0, prev_lead = 0;
   int rst_hi_toggles = 0, rst_hi_cycles = 0;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at edge %0d", req, act, exp, e);
      end
   endtask

   // One sample cycle: drive, clock, model, compare after the falling edge.
   task automatic step(input bit r);
      int i;
      bit fall, load;
      smp_i = 8'((e + 1) * 37 + 11);
      sync_rst_i = r;
      @(posedge clk);
      e++;
      i = e + OFS;
      dh[i] = smp_i;
      rh[i] = r;
      fall = rh[i-7] && !rh[i-6];
      ph[i] = fall ? 1'b1 : !ph[i-1];
      load = ph[i] && !ph[i-1];
      if (load) begin lead_m = dh[i-7]; trail_m = dh[i-8]; end
      @(negedge clk); #1;
      chk("R2/R8 dready", dready_o, ph[i]);
      chk("R6 rst_out", rst_out_o, rh[i-6]);
      chk("R3 lead", lead_o, lead_m);
      chk("R4 trail", trail_o, trail_m);
      if (fall && ph[i-1]) begin
         chk("R8 held level", dready_o, prev_dr);
         swallow_pend = 1;
      end
      if (prev_lead != lead_o) begin
         if (last_chg >= 0) chk("R10 update spacing", e - last_chg, swallow_pend ? 3 : 2);
         swallow_pend = 0;
         last_chg = e;
      end
      if (rst_out_o && rh[i-7]) begin
         rst_hi_cycles++;
         if (dready_o != prev_dr) rst_hi_toggles++;
      end
      prev_lead = lead_o;
      prev_dr = dready_o;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         fails++; total++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < HMAX; k++) begin dh[k] = 0; rh[k] = 0; ph[k] = 0; end
      // R1: power-on state held regardless of inputs
      smp_i = 8'hA5; sync_rst_i = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk); #1;
      chk("R1 dready", dready_o, 0);
      chk("R1 rst_out", rst_out_o, 0);
      chk("R1 lead", lead_o, 0);
      chk("R1 trail", trail_o, 0);
      sync_rst_i = 1'b0;
      por_n = 1'b1;
      // R2: first rise after the first rising edge; steady run with no reset
      for (int c = 0; c < 24; c++) step(1'b0);
      // Table walk: R6-R10 under varied pulse lengths and phases (R9)
      for (int s = 0; s < NSCN; s++) begin
         int tog0, cyc0;
         for (int c = 0; c < SCN[s][0]; c++) step(1'b0);
         tog0 = rst_hi_toggles; cyc0 = rst_hi_cycles;
         for (int c = 0; c < SCN[s][1]; c++) step(1'b1);
         for (int c = 0; c < 14; c++) step(1'b0);
         // R7: every cycle with the reset output held high shows a ready-clock toggle
         chk("R7 toggles while rst_out high", rst_hi_toggles - tog0, rst_hi_cycles - cyc0);
         chk("R9 pulse seen on rst_out", (rst_hi_cycles - cyc0) + 1, SCN[s][1]);
      end
      // Directed: back-to-back one-cycle pulses two cycles apart
      step(1'b1); step(1'b0); step(1'b1);
      for (int c = 0; c < 16; c++) step(1'b0);
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule